// File: doc/BRIEF.md
# Time-Base Bit Fixed-Interval Timer

This block raises a periodic interrupt from a free-running 64-bit time base that lives elsewhere on the chip. It watches one bit of that count and records an event each time the bit goes from 0 to 1. Watching bit n gives one event every 2^(n+1) time-base ticks. Each event sets a sticky status flag. The interrupt line is that flag gated by an enable bit in the control word.

Two inputs choose the watched bit: a 2-bit period field and a 4-bit extension field of the control word. A mode input picks between two decodings. The extended decoding combines both fields into a 6-bit value and inverts it against 63. The table decoding uses the 2-bit field as an index into four loadable 6-bit bit positions. Software clears the flag by writing a status word with the flag's bit set (write-one-to-clear).

Top module: `fit_timer`

## Requirements
- R1: After reset `status_o` and `irq_o` are 0 and the position table holds 17, 21, 25, 29 at indices 0, 1, 2, 3.
- R2: With `ext_mode`=1 the watched bit is 63 minus ({ext, per}), where per is `ctrl_word[25:24]` and ext is `ctrl_word[16:13]` (ext in the upper four bits). Bit 0 is the least significant time-base bit.
- R3: With `ext_mode`=0 the watched bit is the table entry indexed by `ctrl_word[25:24]`.
- R4: A table write (`tbl_we`, `tbl_idx`, `tbl_pos`) replaces that entry from the next clock edge onward.
- R5: A 0-to-1 change of the watched bit sets `status_o` at the next clock edge. Watching bit n yields one event per 2^(n+1) ticks, the first at time-base value 2^n when counting from 0.
- R6: A 1-to-0 change or an unchanged watched bit does not set the flag.
- R7: A change of the watched bit position (field or mode change) produces no event, even when the newly watched bit reads 1.
- R8: A status write (`clr_we`) with `clr_word[26]`=1 clears the flag. A write with bit 26 at 0 leaves the flag unchanged, whatever the other bits are.
- R9: An event and a clearing write in the same cycle leave the flag set.
- R10: `irq_o` equals the flag ANDed with `ctrl_word[23]`, with no clock delay. Setting the enable while the flag is set raises `irq_o` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_value | input | 64 | Free-running time-base count |
| ext_mode | input | 1 | 1: extended field decoding, 0: table decoding |
| ctrl_word | input | 32 | Control word: period [25:24], extension [16:13], enable [23] |
| clr_we | input | 1 | Status write strobe |
| clr_word | input | 32 | Status write data; bit 26 clears the flag |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 2 | Table entry index |
| tbl_pos | input | 6 | Bit position to store |
| status_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Level interrupt |

## Verification
An edge on the watched bit is compared against a registered copy of that bit. The flag therefore shows the event just after the first clock edge that sees the new time-base value. The bench drives each value at a falling edge and samples one time unit after the next rising edge. A clearing write and a table write also act at that single edge, so they are sampled the same way. `irq_o` responds to the enable with no clock, so the enable check samples one time unit after changing `ctrl_word`, with no clock edge in between.

// File: rtl/fit_pkg.sv
package fit_pkg;
    // Control word fields
    localparam int PER_LO  = 24;   // 2-bit period field
    localparam int EXT_LO  = 13;   // 4-bit extension field
    localparam int IEN_BIT = 23;   // interrupt enable
    // Status word field
    localparam int FLG_BIT = 26;   // sticky flag, write-one-to-clear

    localparam int PER_W = 2;
    localparam int EXT_W = 4;
endpackage

// File: rtl/fit_bit_select.sv
module fit_bit_select
    import fit_pkg::*;
#(
    parameter int TB_W    = 64,
    parameter int POS_W   = $clog2(TB_W),
    parameter int ENTRIES = 1 << PER_W,
    parameter logic [ENTRIES*POS_W-1:0] TBL_INIT = {6'd29, 6'd25, 6'd21, 6'd17}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ext_mode,
    input  logic [PER_W-1:0]           per_fld,
    input  logic [EXT_W-1:0]           ext_fld,
    input  logic                       tbl_we,
    input  logic [$clog2(ENTRIES)-1:0] tbl_idx,
    input  logic [POS_W-1:0]           tbl_pos,
    output logic [POS_W-1:0]           target
);
    localparam logic [POS_W-1:0] TOP_POS = POS_W'(TB_W - 1);

    typedef struct packed {
        logic [ENTRIES-1:0][POS_W-1:0] tbl;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tbl_we) begin
            st_d.tbl[tbl_idx] = tbl_pos;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.tbl[i] <= TBL_INIT[i*POS_W +: POS_W];
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (ext_mode) begin
            target = TOP_POS - POS_W'({ext_fld, per_fld});
        end else begin
            target = st_q.tbl[per_fld];
        end
    end

    // A written entry must read back at the next edge
    AST_TBL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> (st_q.tbl[$past(tbl_idx)] == $past(tbl_pos))); // R4
endmodule

// File: rtl/fit_edge_detect.sv
module fit_edge_detect #(
    parameter int TB_W  = 64,
    parameter int POS_W = $clog2(TB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  tb_value,
    input  logic [POS_W-1:0] target,
    output logic             rise
);
    typedef struct packed {
        logic             prev;
        logic [POS_W-1:0] tgt;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        cur_bit;
    logic        same_sel;

    always_comb begin
        cur_bit  = tb_value[target];
        same_sel = (target == st_q.tgt);
        // On reselection the stored bit is reloaded from the new position
        st_d.prev = cur_bit;
        st_d.tgt  = target;
        rise      = same_sel & cur_bit & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RISE_SAME_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (target == $past(target))); // R7
    AST_RISE_WAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> !$past(tb_value[target])); // R6
endmodule

// File: rtl/fit_timer.sv
module fit_timer
    import fit_pkg::*;
#(
    parameter int TB_W    = 64,
    parameter int POS_W   = $clog2(TB_W),
    parameter int ENTRIES = 1 << PER_W,
    parameter logic [ENTRIES*POS_W-1:0] TBL_INIT = {6'd29, 6'd25, 6'd21, 6'd17}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TB_W-1:0]            tb_value,
    input  logic                       ext_mode,
    input  logic [31:0]                ctrl_word,
    input  logic                       clr_we,
    input  logic [31:0]                clr_word,
    input  logic                       tbl_we,
    input  logic [$clog2(ENTRIES)-1:0] tbl_idx,
    input  logic [POS_W-1:0]           tbl_pos,
    output logic                       status_o,
    output logic                       irq_o
);
    logic [POS_W-1:0] target;
    logic             rise;
    logic             clr_hit;
    logic             irq_en;
    logic             unused_bits;

    assign unused_bits = ^{ctrl_word[31:PER_LO+PER_W], ctrl_word[PER_LO-1+0 -: 1] & 1'b0,
                           ctrl_word[IEN_BIT-1:EXT_LO+EXT_W], ctrl_word[EXT_LO-1:0],
                           clr_word[31:FLG_BIT+1], clr_word[FLG_BIT-1:0]};

    fit_bit_select #(
        .TB_W(TB_W), .POS_W(POS_W), .ENTRIES(ENTRIES), .TBL_INIT(TBL_INIT)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_mode(ext_mode),
        .per_fld (ctrl_word[PER_LO +: PER_W]),
        .ext_fld (ctrl_word[EXT_LO +: EXT_W]),
        .tbl_we  (tbl_we),
        .tbl_idx (tbl_idx),
        .tbl_pos (tbl_pos),
        .target  (target)
    );

    fit_edge_detect #(.TB_W(TB_W), .POS_W(POS_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tb_value(tb_value),
        .target  (target),
        .rise    (rise)
    );

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        clr_hit = clr_we & clr_word[FLG_BIT];
        irq_en  = ctrl_word[IEN_BIT];
        st_d    = st_q;
        if (clr_hit) begin
            st_d.flag = 1'b0;
        end
        if (rise) begin
            st_d.flag = 1'b1;   // a new event outranks a clear
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.flag;
    assign irq_o    = st_q.flag & irq_en;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> status_o); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_word[FLG_BIT] && !rise) |=> !status_o); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !(clr_we && clr_word[FLG_BIT])) |=> status_o); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o && !rise) |=> !status_o); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[IEN_BIT] |-> !irq_o); // R10
endmodule

// File: tb/fit_timer_bench.sv
module fit_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tb_value = '0;
    logic        ext_mode = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_word = '0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_idx = '0;
    logic [5:0]  tbl_pos = '0;
    logic        status_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fit_timer u_fit_timer (
        .clk(clk), .rst_n(rst_n), .tb_value(tb_value), .ext_mode(ext_mode),
        .ctrl_word(ctrl_word), .clr_we(clr_we), .clr_word(clr_word),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_pos(tbl_pos),
        .status_o(status_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] mk_ctrl(input logic [1:0] per, input logic [3:0] ext,
                                            input logic en);
        return (32'(per) << 24) | (32'(ext) << 13) | (32'(en) << 23);
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a time-base value at the falling edge, sample after the rising edge
    task automatic step(input logic [63:0] v);
        @(negedge clk);
        tb_value = v;
        @(posedge clk);
        #1;
        clr_we = 1'b0;
        tbl_we = 1'b0;
    endtask

    task automatic clear_at(input logic [63:0] v);
        clr_we   = 1'b1;
        clr_word = 32'h0400_0000;
        step(v);
    endtask

    task automatic t_reset;
        check(status_o == 1'b0, "R1 status", status_o, 0);
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    endtask

    // watched bit 3: {ext,per} = 60 -> 63-60 = 3
    task automatic t_ext_period;
        int events = 0;
        int first = -1;
        ext_mode  = 1'b1;
        ctrl_word = mk_ctrl(2'd0, 4'd15, 1'b1);
        step(0);
        clear_at(0);
        for (int v = 1; v < 32; v++) begin
            step(64'(v));
            if (status_o) begin
                events++;
                if (first < 0) first = v;
                check(irq_o == 1'b1, "R10 irq with flag", irq_o, 1);
                clear_at(64'(v));
            end
        end
        check(events == 2, "R2 event count bit3", events, 2);
        check(first == 8, "R5 first event bit3", first, 8);
    endtask

    task automatic t_table_default;
        ext_mode  = 1'b0;
        ctrl_word = mk_ctrl(2'd0, 4'd0, 1'b1);
        step(64'h1_FFFF);
        clear_at(64'h1_FFFF);
        step(64'h2_0000);
        check(status_o == 1'b1, "R3 default entry 17", status_o, 1);
        clear_at(64'h2_0000);
    endtask

    task automatic t_table_load;
        int events = 0;
        int first = -1;
        tbl_we  = 1'b1;
        tbl_idx = 2'd2;
        tbl_pos = 6'd5;
        step(0);
        ctrl_word = mk_ctrl(2'd2, 4'd0, 1'b1);
        step(0);
        clear_at(0);
        for (int v = 1; v < 64; v++) begin
            step(64'(v));
            if (status_o) begin
                events++;
                if (first < 0) first = v;
                clear_at(64'(v));
            end
        end
        check(events == 1, "R4 loaded entry events", events, 1);
        check(first == 32, "R4 loaded entry first", first, 32);
    endtask

    task automatic t_reselect;
        ext_mode  = 1'b1;
        ctrl_word = mk_ctrl(2'd0, 4'd15, 1'b1);   // bit 3
        step(64'h400);
        clear_at(64'h400);
        ctrl_word = mk_ctrl(2'd1, 4'd13, 1'b1);   // 63-53 = bit 10, reads 1
        step(64'h400);
        check(status_o == 1'b0, "R7 reselect no event", status_o, 0);
        step(64'h400);
        check(status_o == 1'b0, "R7 reselect steady", status_o, 0);
        ext_mode = 1'b0;                           // table idx 1 = bit 21
        step(64'h20_0000);
        check(status_o == 1'b0, "R7 mode change no event", status_o, 0);
    endtask

    task automatic t_fall;
        ext_mode  = 1'b1;
        ctrl_word = mk_ctrl(2'd0, 4'd15, 1'b1);
        step(0);
        clear_at(0);
        step(8);
        check(status_o == 1'b1, "R5 rise sets", status_o, 1);
        clear_at(8);
        step(0);
        check(status_o == 1'b0, "R6 fall no event", status_o, 0);
        step(0);
        check(status_o == 1'b0, "R6 steady no event", status_o, 0);
    endtask

    task automatic t_w1c;
        step(8);
        clr_we   = 1'b1;
        clr_word = 32'hFBFF_FFFF;
        step(8);
        check(status_o == 1'b1, "R8 other bits keep flag", status_o, 1);
        clear_at(8);
        check(status_o == 1'b0, "R8 bit26 clears", status_o, 0);
        check(irq_o == 1'b0, "R8 irq drops", irq_o, 0);
        step(0);
    endtask

    task automatic t_set_wins;
        step(0);
        clear_at(0);
        clr_we   = 1'b1;
        clr_word = 32'h0400_0000;
        step(8);
        check(status_o == 1'b1, "R9 set beats clear", status_o, 1);
        clear_at(8);
        step(0);
    endtask

    task automatic t_late_enable;
        ctrl_word = mk_ctrl(2'd0, 4'd15, 1'b0);
        step(8);
        check(status_o == 1'b1, "R5 flag without enable", status_o, 1);
        check(irq_o == 1'b0, "R10 masked irq", irq_o, 0);
        @(negedge clk);
        ctrl_word = mk_ctrl(2'd0, 4'd15, 1'b1);
        #1;
        check(irq_o == 1'b1, "R10 immediate irq", irq_o, 1);
        clear_at(8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_ext_period();
        t_table_default();
        t_table_load();
        t_reselect();
        t_fall();
        t_w1c();
        t_set_wins();
        t_late_enable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule